// File: doc/BRIEF.md
# EPP Cycle Controller

This block connects a host I/O bus to a parallel-port peripheral that uses the enhanced (EPP, version 1.7) handshake. A host read or write of the port's data register or address register becomes one peripheral handshake. The block drives the matching active-low strobe and the write-direction line. It also steers the peripheral data bus and holds the host bus wait-ready low while the peripheral asks for more time.

A cycle counter acts as a watchdog. If a host access is still open after the configured limit (10 ms by default), the block abandons the handshake and raises a sticky time-out flag. From then on it keeps the host ready line released. When no handshake is in progress, the port behaves as a plain or bidirectional port. The general control lines mirror the control bits and the direction control sets the data bus direction. Host strobes and the peripheral wait line are asynchronous and pass through two-flop synchronisers. Every output comes from a register.

Top module: `epp_cycle_ctrl`

## Requirements
- R1: During and right after reset, both handshake strobes (`per_dstb_n`, `per_astb_n`) are high, `host_rdy` is high and `timeout_flag` is 0.
- R2: With `epp_en`=1, a host write (`host_wr_n` low) with `host_addr_sel`=0 drives `per_dstb_n` low and keeps `per_astb_n` high. It drives `per_write_n` low and `per_data_oe` high, and `per_data_out` carries `host_wdata`. The two strobes are never low together.
- R3: A host write with `host_addr_sel`=1 drives `per_astb_n` low and keeps `per_dstb_n` high.
- R4: A host read (`host_rd_n` low) drives the selected strobe low, `per_write_n` high and `per_data_oe` low. After the cycle, `host_rdata` holds the `per_data_in` value seen while the strobe was low.
- R5: While a handshake is open and `per_wait_n` is low, `host_rdy` is low. It returns high once `per_wait_n` is high again.
- R6: When the host releases its strobe, the peripheral strobe returns high. `per_data_out` keeps the `host_wdata` value captured at that release, even if `host_wdata` changes afterwards.
- R7: If the host releases its strobe while `per_wait_n` is still low, the handshake stays open with the strobe low. It closes once `per_wait_n` goes high.
- R8: A handshake still open after TIMEOUT_US microseconds of clock cycles is abandoned. Its strobe goes high, `host_rdy` goes high and `timeout_flag` goes to 1. While the flag is 1, `host_rdy` stays high.
- R9: `timeout_flag` stays 1 after the host releases. It clears only on a one-cycle `stat_clr` pulse.
- R10: When no handshake is open, `per_strobe_n`, `per_autofd_n` and `per_init_n` are the inverses of `ctl_strobe`, `ctl_autofd` and `ctl_init`, and `per_data_oe` is the inverse of `ctl_dir`. With `epp_en`=1, `per_write_n` equals `ctl_dir`.
- R11: With `epp_en`=0, host strobes have no effect. Both handshake strobes stay high, `host_rdy` stays high and `per_write_n` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| epp_en | input | 1 | Enhanced mode selected |
| ctl_dir | input | 1 | Direction control bit (1 = peripheral drives bus) |
| ctl_strobe | input | 1 | Control bit for the plain strobe line |
| ctl_autofd | input | 1 | Control bit for the auto-feed line |
| ctl_init | input | 1 | Control bit for the init line |
| stat_clr | input | 1 | Host writes 1 to status bit 0: clears the time-out flag |
| host_rd_n | input | 1 | Host read strobe, active low, asynchronous |
| host_wr_n | input | 1 | Host write strobe, active low, asynchronous |
| host_addr_sel | input | 1 | 1 = address register, 0 = data register |
| host_wdata | input | DW | Host write data |
| host_rdata | output | DW | Data captured from the peripheral |
| host_rdy | output | 1 | Host ready, low stretches the host cycle |
| timeout_flag | output | 1 | Status bit 0: watchdog expired |
| per_wait_n | input | 1 | Peripheral wait, active low, asynchronous |
| per_data_in | input | DW | Peripheral data bus input |
| per_data_out | output | DW | Peripheral data bus output |
| per_data_oe | output | 1 | Output enable for the peripheral data bus |
| per_dstb_n | output | 1 | Data strobe, active low |
| per_astb_n | output | 1 | Address strobe, active low |
| per_write_n | output | 1 | Write direction, low for writes |
| per_strobe_n | output | 1 | Plain strobe line |
| per_autofd_n | output | 1 | Auto-feed line |
| per_init_n | output | 1 | Init line |

## Verification
The assertions take certain things for granted about the inputs. `stat_clr` is a single-cycle pulse. The host never opens a new access before the previous one has been released and the block has returned to idle. The host holds `host_addr_sel` steady while a strobe is low. The bench respects all three. Each scenario drives a single host strobe and waits well over the synchroniser and output-register latency before it samples, then releases and waits again. `per_data_in` is held steady while a read strobe is low, so the captured value is well defined.

// File: rtl/epp_pkg.sv
package epp_pkg;
  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_ACTIVE = 2'd1,
    ST_ABORT  = 2'd2
  } epp_state_e;
endpackage

// File: rtl/epp_sync.sv
module epp_sync #(
  parameter int WIDTH  = 3,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d_async,
  output logic [WIDTH-1:0] q_sync
);
  for (genvar b = 0; b < WIDTH; b++) begin : g_bit
    logic [STAGES-1:0] chain;
    always_ff @(posedge clk) begin
      if (rst) chain <= '1;
      else     chain <= {chain[STAGES-2:0], d_async[b]};
    end
    assign q_sync[b] = chain[STAGES-1];
  end
endmodule

// File: rtl/epp_watchdog.sv
module epp_watchdog #(
  parameter int LIMIT = 2_500_000
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  output logic expire
);
  localparam int CW = $clog2(LIMIT + 1);
  localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      cnt    <= '0;
      expire <= 1'b0;
    end else begin
      if (cnt != LAST) cnt <= cnt + 1'b1;
      expire <= (cnt == LAST);
    end
  end

  assert_cnt_bound_R8: assert property (@(posedge clk) disable iff (rst)
    cnt <= LAST);
  assert_expire_needs_run_R8: assert property (@(posedge clk) disable iff (rst)
    expire |-> $past(run));
endmodule

// File: rtl/epp_seq.sv
module epp_seq
  import epp_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          epp_en,
  input  logic          rd_s,
  input  logic          wr_s,
  input  logic          wait_s,
  input  logic          addr_sel,
  input  logic [DW-1:0] wdata,
  input  logic          expire,
  input  logic          stat_clr,
  output epp_state_e    state,
  output logic          cyc_read,
  output logic          cyc_addr,
  output logic [DW-1:0] data_q,
  output logic          flag_q,
  output logic          run
);
  logic host_idle;
  assign host_idle = rd_s && wr_s;
  assign run       = (state == ST_ACTIVE);

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= ST_IDLE;
      cyc_read <= 1'b0;
      cyc_addr <= 1'b0;
      data_q   <= '0;
    end else begin
      unique case (state)
        ST_IDLE: begin
          if (epp_en && !host_idle) begin
            state    <= ST_ACTIVE;
            cyc_read <= !rd_s;
            cyc_addr <= addr_sel;
            if (rd_s) data_q <= wdata;
          end
        end
        ST_ACTIVE: begin
          if (expire) begin
            state <= ST_ABORT;
          end else if (host_idle && wait_s) begin
            state <= ST_IDLE;
            if (!cyc_read) data_q <= wdata;
          end
        end
        ST_ABORT: begin
          if (host_idle) state <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst)                                 flag_q <= 1'b0;
    else if (state == ST_ACTIVE && expire)   flag_q <= 1'b1;
    else if (stat_clr)                       flag_q <= 1'b0;
  end

  assert_abort_cause_R8: assert property (@(posedge clk) disable iff (rst)
    (state == ST_ABORT && $past(state) != ST_ABORT) |-> $past(expire));
  assert_close_needs_wait_R7: assert property (@(posedge clk) disable iff (rst)
    ($past(state) == ST_ACTIVE && state == ST_IDLE) |-> $past(wait_s));
  assert_no_start_disabled_R11: assert property (@(posedge clk) disable iff (rst)
    ($past(state) == ST_IDLE && state == ST_ACTIVE) |-> $past(epp_en));
endmodule

// File: rtl/epp_cycle_ctrl.sv
module epp_cycle_ctrl
  import epp_pkg::*;
#(
  parameter int DW         = 8,
  parameter int CLK_HZ     = 250_000_000,
  parameter int TIMEOUT_US = 10_000,
  parameter int SYNC_STG   = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          epp_en,
  input  logic          ctl_dir,
  input  logic          ctl_strobe,
  input  logic          ctl_autofd,
  input  logic          ctl_init,
  input  logic          stat_clr,
  input  logic          host_rd_n,
  input  logic          host_wr_n,
  input  logic          host_addr_sel,
  input  logic [DW-1:0] host_wdata,
  output logic [DW-1:0] host_rdata,
  output logic          host_rdy,
  output logic          timeout_flag,
  input  logic          per_wait_n,
  input  logic [DW-1:0] per_data_in,
  output logic [DW-1:0] per_data_out,
  output logic          per_data_oe,
  output logic          per_dstb_n,
  output logic          per_astb_n,
  output logic          per_write_n,
  output logic          per_strobe_n,
  output logic          per_autofd_n,
  output logic          per_init_n
);
  localparam int CYC_PER_US = CLK_HZ / 1_000_000;
  localparam int LIMIT      = CYC_PER_US * TIMEOUT_US;

  logic [2:0]    sync_q;
  logic          rd_s, wr_s, wait_s;
  epp_state_e    state;
  logic          cyc_read, cyc_addr, flag_q, run, expire;
  logic [DW-1:0] data_q;
  logic          active;

  epp_sync #(.WIDTH(3), .STAGES(SYNC_STG)) u_sync (
    .clk(clk), .rst(rst),
    .d_async({per_wait_n, host_wr_n, host_rd_n}),
    .q_sync(sync_q)
  );
  assign rd_s   = sync_q[0];
  assign wr_s   = sync_q[1];
  assign wait_s = sync_q[2];

  epp_watchdog #(.LIMIT(LIMIT)) u_wdog (
    .clk(clk), .rst(rst), .run(run), .expire(expire)
  );

  epp_seq #(.DW(DW)) u_seq (
    .clk(clk), .rst(rst), .epp_en(epp_en),
    .rd_s(rd_s), .wr_s(wr_s), .wait_s(wait_s),
    .addr_sel(host_addr_sel), .wdata(host_wdata),
    .expire(expire), .stat_clr(stat_clr),
    .state(state), .cyc_read(cyc_read), .cyc_addr(cyc_addr),
    .data_q(data_q), .flag_q(flag_q), .run(run)
  );

  assign active = (state == ST_ACTIVE);

  always_ff @(posedge clk) begin
    if (rst) begin
      per_dstb_n   <= 1'b1;
      per_astb_n   <= 1'b1;
      host_rdy     <= 1'b1;
      timeout_flag <= 1'b0;
      per_data_oe  <= 1'b0;
      per_write_n  <= 1'b1;
      per_strobe_n <= 1'b1;
      per_autofd_n <= 1'b1;
      per_init_n   <= 1'b1;
      per_data_out <= '0;
      host_rdata   <= '0;
    end else begin
      per_dstb_n   <= !(active && !cyc_addr);
      per_astb_n   <= !(active && cyc_addr);
      host_rdy     <= !(active && !wait_s && !flag_q);
      timeout_flag <= flag_q;
      per_data_out <= data_q;
      if (active && cyc_read) host_rdata <= per_data_in;
      if (state == ST_IDLE) begin
        per_data_oe  <= !ctl_dir;
        per_write_n  <= epp_en ? ctl_dir : 1'b1;
        per_strobe_n <= !ctl_strobe;
        per_autofd_n <= !ctl_autofd;
        per_init_n   <= !ctl_init;
      end else begin
        per_data_oe  <= !cyc_read;
        per_write_n  <= cyc_read;
      end
    end
  end

  assert_one_strobe_R2: assert property (@(posedge clk) disable iff (rst)
    !(!per_dstb_n && !per_astb_n));
  assert_read_tristate_R4: assert property (@(posedge clk) disable iff (rst)
    ((!per_dstb_n || !per_astb_n) && per_write_n) |-> !per_data_oe);
  assert_flag_frees_host_R8: assert property (@(posedge clk) disable iff (rst)
    timeout_flag |-> host_rdy);
  assert_flag_clear_cause_R9: assert property (@(posedge clk) disable iff (rst)
    $fell(timeout_flag) |-> $past(stat_clr, 2));
endmodule

// File: tb/epp_cycle_ctrl_tb.sv
`timescale 1ns/1ps
module epp_cycle_ctrl_tb;
  localparam int DW = 8;

  logic clk = 1'b0;
  logic rst;
  logic epp_en, ctl_dir, ctl_strobe, ctl_autofd, ctl_init, stat_clr;
  logic host_rd_n, host_wr_n, host_addr_sel;
  logic [DW-1:0] host_wdata, host_rdata, per_data_in, per_data_out;
  logic host_rdy, timeout_flag, per_wait_n, per_data_oe;
  logic per_dstb_n, per_astb_n, per_write_n, per_strobe_n, per_autofd_n, per_init_n;

  int n_chk = 0;
  int n_bad = 0;

  always #2 clk = ~clk;

  epp_cycle_ctrl #(.DW(DW), .CLK_HZ(250_000_000), .TIMEOUT_US(1)) u_dut (
    .clk(clk), .rst(rst), .epp_en(epp_en), .ctl_dir(ctl_dir),
    .ctl_strobe(ctl_strobe), .ctl_autofd(ctl_autofd), .ctl_init(ctl_init),
    .stat_clr(stat_clr), .host_rd_n(host_rd_n), .host_wr_n(host_wr_n),
    .host_addr_sel(host_addr_sel), .host_wdata(host_wdata),
    .host_rdata(host_rdata), .host_rdy(host_rdy), .timeout_flag(timeout_flag),
    .per_wait_n(per_wait_n), .per_data_in(per_data_in),
    .per_data_out(per_data_out), .per_data_oe(per_data_oe),
    .per_dstb_n(per_dstb_n), .per_astb_n(per_astb_n),
    .per_write_n(per_write_n), .per_strobe_n(per_strobe_n),
    .per_autofd_n(per_autofd_n), .per_init_n(per_init_n)
  );

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic t_reset;
    rst = 1'b1; epp_en = 1'b1; ctl_dir = 1'b0; ctl_strobe = 1'b0;
    ctl_autofd = 1'b0; ctl_init = 1'b0; stat_clr = 1'b0;
    host_rd_n = 1'b1; host_wr_n = 1'b1; host_addr_sel = 1'b0;
    host_wdata = '0; per_wait_n = 1'b1; per_data_in = '0;
    cyc(4);
    chk("R1", "dstb", per_dstb_n, 1);
    chk("R1", "astb", per_astb_n, 1);
    chk("R1", "rdy", host_rdy, 1);
    chk("R1", "flag", timeout_flag, 0);
    rst = 1'b0;
    cyc(3);
    chk("R1", "dstb after", per_dstb_n, 1);
    chk("R1", "flag after", timeout_flag, 0);
  endtask

  task automatic t_idle_follow;
    ctl_dir = 1'b1; ctl_strobe = 1'b1; ctl_autofd = 1'b0; ctl_init = 1'b1;
    cyc(4);
    chk("R10", "strobe", per_strobe_n, 0);
    chk("R10", "autofd", per_autofd_n, 1);
    chk("R10", "init", per_init_n, 0);
    chk("R10", "oe dir1", per_data_oe, 0);
    chk("R10", "write_n dir1", per_write_n, 1);
    ctl_dir = 1'b0; ctl_strobe = 1'b0; ctl_autofd = 1'b1;
    cyc(4);
    chk("R10", "oe dir0", per_data_oe, 1);
    chk("R10", "write_n dir0", per_write_n, 0);
    chk("R10", "strobe2", per_strobe_n, 1);
    chk("R10", "autofd2", per_autofd_n, 0);
    ctl_strobe = 1'b0; ctl_autofd = 1'b0; ctl_init = 1'b0;
    cyc(4);
  endtask

  task automatic t_write_data;
    ctl_dir = 1'b0; host_addr_sel = 1'b0; host_wdata = 8'h5A;
    host_wr_n = 1'b0;
    cyc(8);
    chk("R2", "dstb", per_dstb_n, 0);
    chk("R2", "astb", per_astb_n, 1);
    chk("R2", "write_n", per_write_n, 0);
    chk("R2", "oe", per_data_oe, 1);
    chk("R2", "data", per_data_out, 8'h5A);
    host_wdata = 8'h3C;
    cyc(1);
    host_wr_n = 1'b1;
    cyc(8);
    chk("R6", "dstb released", per_dstb_n, 1);
    host_wdata = 8'hFF;
    cyc(6);
    chk("R6", "latched data", per_data_out, 8'h3C);
  endtask

  task automatic t_write_addr;
    host_addr_sel = 1'b1; host_wdata = 8'hA7;
    host_wr_n = 1'b0;
    cyc(8);
    chk("R3", "astb", per_astb_n, 0);
    chk("R3", "dstb", per_dstb_n, 1);
    chk("R3", "data", per_data_out, 8'hA7);
    host_wr_n = 1'b1;
    cyc(8);
    chk("R3", "astb released", per_astb_n, 1);
    host_addr_sel = 1'b0;
  endtask

  task automatic t_read;
    ctl_dir = 1'b1; host_addr_sel = 1'b0; per_data_in = 8'hC3;
    cyc(4);
    host_rd_n = 1'b0;
    cyc(8);
    chk("R4", "dstb", per_dstb_n, 0);
    chk("R4", "write_n", per_write_n, 1);
    chk("R4", "oe", per_data_oe, 0);
    host_rd_n = 1'b1;
    cyc(8);
    chk("R4", "rdata", host_rdata, 8'hC3);
    chk("R4", "dstb released", per_dstb_n, 1);
    per_data_in = 8'h11;
    cyc(4);
    chk("R4", "rdata held", host_rdata, 8'hC3);
  endtask

  task automatic t_wait_stretch;
    per_wait_n = 1'b0;
    host_addr_sel = 1'b1;
    host_rd_n = 1'b0;
    cyc(8);
    chk("R5", "rdy low", host_rdy, 0);
    chk("R5", "astb", per_astb_n, 0);
    per_wait_n = 1'b1;
    cyc(8);
    chk("R5", "rdy high", host_rdy, 1);
    host_rd_n = 1'b1;
    cyc(8);
    chk("R5", "astb released", per_astb_n, 1);
    host_addr_sel = 1'b0;
  endtask

  task automatic t_late_release;
    ctl_dir = 1'b0; host_wdata = 8'h66;
    per_wait_n = 1'b0;
    host_wr_n = 1'b0;
    cyc(8);
    host_wr_n = 1'b1;
    cyc(10);
    chk("R7", "dstb held", per_dstb_n, 0);
    per_wait_n = 1'b1;
    cyc(8);
    chk("R7", "dstb closed", per_dstb_n, 1);
    chk("R7", "no timeout", timeout_flag, 0);
  endtask

  task automatic t_timeout;
    ctl_dir = 1'b1; per_wait_n = 1'b0;
    host_rd_n = 1'b0;
    cyc(20);
    chk("R8", "rdy low before", host_rdy, 0);
    cyc(280);
    chk("R8", "dstb aborted", per_dstb_n, 1);
    chk("R8", "rdy released", host_rdy, 1);
    chk("R8", "flag", timeout_flag, 1);
    host_rd_n = 1'b1; per_wait_n = 1'b1;
    cyc(20);
    chk("R9", "flag sticky", timeout_flag, 1);
    stat_clr = 1'b1;
    cyc(1);
    stat_clr = 1'b0;
    cyc(4);
    chk("R9", "flag cleared", timeout_flag, 0);
  endtask

  task automatic t_disabled;
    epp_en = 1'b0; ctl_dir = 1'b0;
    cyc(4);
    host_rd_n = 1'b0;
    cyc(10);
    chk("R11", "dstb", per_dstb_n, 1);
    chk("R11", "astb", per_astb_n, 1);
    chk("R11", "rdy", host_rdy, 1);
    chk("R11", "write_n", per_write_n, 1);
    host_rd_n = 1'b1;
    cyc(4);
    epp_en = 1'b1;
    cyc(4);
  endtask

  initial begin
    t_reset();
    t_idle_follow();
    t_write_data();
    t_write_addr();
    t_read();
    t_wait_stretch();
    t_late_release();
    t_timeout();
    t_disabled();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (50_000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual hung expected done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule